// File: doc/BRIEF.md
# Memory-Protection Region Matcher

This block holds the settings for one memory-protection region and classifies every access against it. Software loads two 32-bit words through a word-wide register port. The first is an attribute/size word. It carries the enable, a size code, eight subregion-disable bits, an execute-never flag, a permission field and memory-type bits. The second word is the region base address.

For each access the block decides whether the address falls inside the region. It takes the access address, an instruction-fetch flag and a valid strobe. From these it raises a hit flag and, for instruction fetches into an execute-never region, a fault flag. On a hit it passes the permission and memory-type fields to a downstream consumer.

The region size is a power of two chosen by the size code. The region is aligned to its own size. It is split into eight equal subregions, and each one can be removed from the region. Several regions can be combined by instantiating the block more than once and adding priority logic outside it.

Top module: `mpu_rgn_chk`

## Requirements
- R1: After reset both stored words read as zero and `hit_o` and `xn_fault_o` are low.
- R2: Writes are full-word and land on the clock edge. `wr_sel_i`=0 selects the attribute word and `wr_sel_i`=1 selects the base word. A read of the attribute word returns the written value ANDed with 0x173F_FF3F. A read of the base word returns the written value with bits [4:0] cleared. `rd_sel_i` uses the same encoding.
- R3: When attribute bit 0 (enable) is clear, the region never hits.
- R4: With size code S in attribute bits [5:1], the region spans 2^(S+1) bytes. An access hits when address bits [31:S+1] equal the same bits of the base. Base bits below S+1 have no effect.
- R5: Size codes 0 to 3 never hit.
- R6: Size code 31 covers every address, whatever the base.
- R7: When S is 7 or more, attribute bits [15:8] disable subregions. Bit k set removes from the region the addresses whose bits [S:S-2] equal k.
- R8: When S is 6 or less, bits [15:8] have no effect on the hit.
- R9: When attribute bit 28 is set, an instruction fetch (`acc_ifetch_i`=1) that hits raises `xn_fault_o`. Data accesses and misses never fault.
- R10: On a hit, `perm_o` carries attribute bits [26:24] and `mem_type_o` carries bits [21:19]. `share_o`, `cache_o` and `buf_o` carry bits 18, 17 and 16. All of them are zero when there is no hit.
- R11: With `acc_valid_i` low, `hit_o`, `xn_fault_o` and the forwarded fields are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 attribute word, 1 base word |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 1 | Read target: 0 attribute word, 1 base word |
| rd_data_o | output | 32 | Read data |
| acc_valid_i | input | 1 | Access qualifier |
| acc_addr_i | input | 32 | Access address |
| acc_ifetch_i | input | 1 | Access is an instruction fetch |
| hit_o | output | 1 | Access falls in the region |
| xn_fault_o | output | 1 | Instruction fetch into an execute-never region |
| perm_o | output | 3 | Forwarded permission field |
| mem_type_o | output | 3 | Forwarded memory-type field |
| share_o | output | 1 | Forwarded shareable bit |
| cache_o | output | 1 | Forwarded cacheable bit |
| buf_o | output | 1 | Forwarded bufferable bit |

## Verification
A write takes effect on the first rising edge after the strobe is raised. Read data and every access result are combinational from the stored words and the current access inputs, so they are due in the same cycle as the stimulus. The bench drives writes on the falling edge and releases the strobe one full cycle later. It then applies the access inputs and samples the outputs one nanosecond after they change, well away from any rising edge.

// File: rtl/mpu_rgn_pkg.sv
package mpu_rgn_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned SZ_W      = 5;
  localparam int unsigned NUM_SUB   = 8;
  localparam int unsigned SUB_IDX_W = $clog2(NUM_SUB);
  localparam int unsigned SZ_MIN    = 4;  // smallest legal code
  localparam int unsigned SZ_SUB    = 7;  // smallest code with subregions
  localparam int unsigned BASE_LSB  = SZ_MIN + 1;

  localparam logic [WORD_W-1:0] ATTR_MASK = 32'h173F_FF3F;

  typedef struct packed {
    logic               xn;
    logic [2:0]         perm;
    logic [2:0]         mtype;
    logic               shr;
    logic               cach;
    logic               bufb;
    logic [NUM_SUB-1:0] srd;
    logic [SZ_W-1:0]    size;
    logic               en;
  } rgn_cfg_t;

  function automatic rgn_cfg_t unpack_attr(logic [WORD_W-1:0] w);
    rgn_cfg_t c;
    c.xn    = w[28];
    c.perm  = w[26:24];
    c.mtype = w[21:19];
    c.shr   = w[18];
    c.cach  = w[17];
    c.bufb  = w[16];
    c.srd   = w[15:8];
    c.size  = w[5:1];
    c.en    = w[0];
    return c;
  endfunction
endpackage

// File: rtl/mpu_rgn_regs.sv
module mpu_rgn_regs
  import mpu_rgn_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_sel_i,
  output logic [WORD_W-1:0] rd_data_o,
  output rgn_cfg_t          cfg_o,
  output logic [WORD_W-1:0] base_o
);
  logic [WORD_W-1:0]        attr_q;
  logic [WORD_W-1:BASE_LSB] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      attr_q <= '0;
      base_q <= '0;
    end else if (wr_en_i) begin
      if (wr_sel_i) base_q <= wr_data_i[WORD_W-1:BASE_LSB];
      else          attr_q <= wr_data_i & ATTR_MASK;
    end
  end

  assign base_o    = {base_q, {BASE_LSB{1'b0}}};
  assign cfg_o     = unpack_attr(attr_q);
  assign rd_data_o = rd_sel_i ? base_o : attr_q;

  p_attr_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i) |=> (attr_q == ($past(wr_data_i) & ATTR_MASK)));
  p_base_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(base_q));
endmodule

// File: rtl/mpu_rgn_match.sv
module mpu_rgn_match
  import mpu_rgn_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rgn_cfg_t          cfg_i,
  input  logic [WORD_W-1:0] base_i,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int unsigned N_W = SZ_W + 1;

  logic [N_W-1:0]       n_bits;     // region is 2^n_bits bytes
  logic [WORD_W-1:0]    hi_mask;
  logic                 addr_in;
  logic                 size_ok;
  logic                 sub_on;
  logic [SZ_W-1:0]      sub_sh;
  logic [SUB_IDX_W-1:0] sub_idx;
  logic                 sub_off;

  assign n_bits  = {1'b0, cfg_i.size} + N_W'(1);
  assign hi_mask = (n_bits >= N_W'(WORD_W)) ? '0 : ({WORD_W{1'b1}} << n_bits);
  assign addr_in = ((addr_i ^ base_i) & hi_mask) == '0;
  assign size_ok = cfg_i.size >= SZ_W'(SZ_MIN);
  assign sub_on  = cfg_i.size >= SZ_W'(SZ_SUB);
  assign sub_sh  = cfg_i.size - SZ_W'(SUB_IDX_W - 1);

  for (genvar k = 0; k < SUB_IDX_W; k++) begin : g_idx
    assign sub_idx[k] = addr_i[SZ_W'(sub_sh + SZ_W'(k))];
  end

  assign sub_off = sub_on && cfg_i.srd[sub_idx];
  assign hit_o   = valid_i && cfg_i.en && size_ok && addr_in && !sub_off;

  p_no_hit_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.en |-> !hit_o);
  p_no_hit_small_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.size < SZ_W'(SZ_MIN)) |-> !hit_o);
  p_full_space_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cfg_i.en && cfg_i.size == '1 && cfg_i.srd == '0) |-> hit_o);
  p_no_sub_small_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cfg_i.en && size_ok && !sub_on && addr_in) |-> hit_o);
endmodule

// File: rtl/mpu_rgn_chk.sv
module mpu_rgn_chk
  import mpu_rgn_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        wr_sel_i,
  input  logic [31:0] wr_data_i,
  input  logic        rd_sel_i,
  output logic [31:0] rd_data_o,
  input  logic        acc_valid_i,
  input  logic [31:0] acc_addr_i,
  input  logic        acc_ifetch_i,
  output logic        hit_o,
  output logic        xn_fault_o,
  output logic [2:0]  perm_o,
  output logic [2:0]  mem_type_o,
  output logic        share_o,
  output logic        cache_o,
  output logic        buf_o
);
  rgn_cfg_t          cfg;
  logic [WORD_W-1:0] base;
  logic              hit;

  mpu_rgn_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .rd_sel_i  (rd_sel_i),
    .rd_data_o (rd_data_o),
    .cfg_o     (cfg),
    .base_o    (base)
  );

  mpu_rgn_match u_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cfg_i   (cfg),
    .base_i  (base),
    .valid_i (acc_valid_i),
    .addr_i  (acc_addr_i),
    .hit_o   (hit)
  );

  assign hit_o      = hit;
  assign xn_fault_o = hit && acc_ifetch_i && cfg.xn;
  assign perm_o     = hit ? cfg.perm  : '0;
  assign mem_type_o = hit ? cfg.mtype : '0;
  assign share_o    = hit && cfg.shr;
  assign cache_o    = hit && cfg.cach;
  assign buf_o      = hit && cfg.bufb;

  p_fault_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xn_fault_o |-> (hit_o && acc_ifetch_i));
  p_fwd_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (perm_o == '0 && mem_type_o == '0 && !share_o && !cache_o && !buf_o));
  p_valid_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> (!hit_o && !xn_fault_o));
endmodule

// File: tb/mpu_rgn_chk_tb_top.sv
module mpu_rgn_chk_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        wr_sel_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        rd_sel_i = 1'b0;
  logic [31:0] rd_data_o;
  logic        acc_valid_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic        acc_ifetch_i = 1'b0;
  logic        hit_o, xn_fault_o, share_o, cache_o, buf_o;
  logic [2:0]  perm_o, mem_type_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk_i = ~clk_i;

  mpu_rgn_chk dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic acc(logic [31:0] a, logic ifetch, logic v = 1'b1);
    acc_addr_i = a; acc_ifetch_i = ifetch; acc_valid_i = v;
    #1;
  endtask

  task automatic t_reset();
    rd_sel_i = 0; #1 check("R1 attr", rd_data_o, 0);
    rd_sel_i = 1; #1 check("R1 base", rd_data_o, 0);
    acc(32'h0, 0); check("R1 hit", hit_o, 0); check("R1 fault", xn_fault_o, 0);
  endtask

  task automatic t_regs();
    wr(0, 32'hFFFF_FFFF); rd_sel_i = 0; #1 check("R2 attr mask", rd_data_o, 32'h173F_FF3F);
    wr(1, 32'h1234_5677); rd_sel_i = 1; #1 check("R2 base low", rd_data_o, 32'h1234_5660);
  endtask

  task automatic t_size();
    wr(1, 32'h2000_03E0);            // low bits must be ignored
    wr(0, (9 << 1) | 1);             // 1 KB
    acc(32'h2000_0000, 0); check("R4 first", hit_o, 1);
    acc(32'h2000_03FF, 0); check("R4 last", hit_o, 1);
    acc(32'h2000_0400, 0); check("R4 above", hit_o, 0);
    acc(32'h1FFF_FFFF, 0); check("R4 below", hit_o, 0);
  endtask

  task automatic t_enable();
    wr(0, (9 << 1));
    acc(32'h2000_0010, 0); check("R3 disabled", hit_o, 0);
  endtask

  task automatic t_small_code();
    wr(1, 32'h0); wr(0, (3 << 1) | 1);
    acc(32'h0, 0); check("R5 code 3", hit_o, 0);
    acc(32'h4, 0); check("R5 code 3 b", hit_o, 0);
  endtask

  task automatic t_full();
    wr(1, 32'h8000_0000); wr(0, (31 << 1) | 1);
    acc(32'hFFFF_FFFF, 0); check("R6 top", hit_o, 1);
    acc(32'h0000_0000, 0); check("R6 bottom", hit_o, 1);
  endtask

  task automatic t_subregion();
    wr(1, 32'h2000_0000); wr(0, (32'h04 << 8) | (9 << 1) | 1);
    acc(32'h2000_0100, 0); check("R7 sub2 start", hit_o, 0);
    acc(32'h2000_017F, 0); check("R7 sub2 end", hit_o, 0);
    acc(32'h2000_0180, 0); check("R7 sub3", hit_o, 1);
    acc(32'h2000_00FF, 0); check("R7 sub1", hit_o, 1);
  endtask

  task automatic t_small_sub();
    wr(1, 32'h4000_0000); wr(0, (32'hFF << 8) | (6 << 1) | 1);
    acc(32'h4000_0010, 0); check("R8 srd ignored", hit_o, 1);
    acc(32'h4000_0070, 0); check("R8 srd ignored hi", hit_o, 1);
  endtask

  task automatic t_xn();
    wr(1, 32'h2000_0000); wr(0, (1 << 28) | (9 << 1) | 1);
    acc(32'h2000_0020, 1); check("R9 fetch fault", xn_fault_o, 1);
    acc(32'h2000_0020, 0); check("R9 data ok", xn_fault_o, 0);
    acc(32'h3000_0000, 1); check("R9 miss ok", xn_fault_o, 0);
  endtask

  task automatic t_fwd();
    wr(0, (5 << 24) | (3 << 19) | (1 << 18) | (1 << 16) | (9 << 1) | 1);
    acc(32'h2000_0040, 0);
    check("R10 perm", perm_o, 5); check("R10 type", mem_type_o, 3);
    check("R10 sh/c/b", {share_o, cache_o, buf_o}, 3'b101);
    acc(32'h2100_0000, 0);
    check("R10 miss", {perm_o, mem_type_o, share_o, cache_o, buf_o}, 0);
  endtask

  task automatic t_valid();
    wr(0, (1 << 28) | (5 << 24) | (9 << 1) | 1);
    acc(32'h2000_0040, 1, 0);
    check("R11 hit", hit_o, 0); check("R11 fault", xn_fault_o, 0);
    check("R11 perm", perm_o, 0);
  endtask

  initial begin
    #200_000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    #23 rst_ni = 1'b1;
    t_reset();
    t_regs();
    t_size();
    t_enable();
    t_small_code();
    t_full();
    t_subregion();
    t_small_sub();
    t_xn();
    t_fwd();
    t_valid();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule